// File: doc/BRIEF.md
# Touch Sample Burst Filter

This block turns one burst of packed touch samples, waiting in an external sample FIFO, into a single filtered touch report. A one-cycle start pulse, typically the FIFO's threshold interrupt, launches a burst. The block checks the FIFO's overrun flag, pops up to four words through a ready/valid handshake, and inverts each 10-bit axis field against full scale. It then decides whether the pen was still down at the end of the burst.

A valid touch needs a full burst of four samples, and the pen flag of the last sample must show pen down. In that case the reported X and Y are the truncated mean of the two middle samples, which removes the settling error of the first sample and the lift-off error of the last. Every other completed burst reports touch-up. An overrun at start empties the FIFO and produces no report.

Top module: `touch_burst_filter`

## Requirements
- R1: After reset, popReady, reportValid and touchDown are 0 and coordX and coordY are 0.
- R2: A burst pops at most four words. It ends early, with fewer pops, when fifoEmpty is 1 while the block is collecting. Words left beyond the fourth stay in the FIFO.
- R3: Each sample word carries raw X in bits 25:16, raw Y in bits 9:0 and the pen flag in bit 31 (1 = pen up). Each axis value is inverted as 0x3FF minus the raw field.
- R4: When touch-down is reported, coordX and coordY are each the inverted values of samples 1 and 2 (zero-based) added at 11-bit width and halved with truncation. The result stays within 0 to 0x3FF, including when both raw fields are 0.
- R5: touchDown is 1 in a report only when exactly four words were popped and bit 31 of the fourth word is 0. Pen flags of earlier samples do not matter.
- R6: Every other non-overrun burst reports touchDown = 0 with coordX = coordY = 0.
- R7: If fifoOverrun is 1 when a burst starts, the block pops words until fifoEmpty is 1 and raises no reportValid for that burst.
- R8: Each non-overrun burst produces exactly one reportValid pulse, one cycle wide, with touchDown, coordX and coordY valid in that cycle.
- R9: A startPulse that arrives while a burst is in progress is ignored and does not restart the burst.
- R10: A word is popped in a cycle where popReady and fifoValid are both 1. popReady is never 1 while fifoEmpty is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to process a burst |
| fifoEmpty | input | 1 | FIFO holds no words |
| fifoOverrun | input | 1 | FIFO has overflowed |
| fifoValid | input | 1 | FIFO head word is presented on fifoData |
| fifoData | input | 32 | FIFO head word |
| popReady | output | 1 | Block accepts the head word this cycle |
| reportValid | output | 1 | One-cycle strobe marking a finished report |
| touchDown | output | 1 | Report shows a valid pen-down touch |
| coordX | output | 10 | Filtered inverted X coordinate |
| coordY | output | 10 | Filtered inverted Y coordinate |

## Verification
A sample counter that drifts shows up at the ports in the same report. Touch-down appears after three pops, or is lost after four, and the pop count seen by the FIFO model differs from the number of words it supplied. An accumulator that adds the wrong sample index, or that drops the carry, gives a coordinate off by a predictable amount in the report cycle. The all-zero raw case exposes the carry. A controller stuck in a busy state shows within a few cycles as a missing report or as extra pops that empty words belonging to the next burst.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  typedef struct packed {
    logic clear;
    logic capture;
    logic publish;
  } ctrlStrobe_t;
endpackage

// File: rtl/tbf_datapath.sv
module tbf_datapath
  import tbf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 10,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int BURST   = 4,
  parameter int AVG_A   = 1,
  parameter int AVG_B   = 2,
  parameter int CNT_W   = $clog2(BURST + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  fifoData,
  output logic [CNT_W-1:0]   sampleCount,
  output logic               reportValid,
  output logic               touchDown,
  output logic [COORD_W-1:0] coordX,
  output logic [COORD_W-1:0] coordY
);
  localparam logic [COORD_W-1:0] FULL_SCALE = {COORD_W{1'b1}};
  localparam logic [CNT_W-1:0]   BURST_C    = CNT_W'(BURST);
  localparam logic [CNT_W-1:0]   IDX_A      = CNT_W'(AVG_A);
  localparam logic [CNT_W-1:0]   IDX_B      = CNT_W'(AVG_B);

  logic [COORD_W-1:0] invX, invY;
  logic [COORD_W:0]   sumX, sumY;
  logic               penLast;
  logic               isAvgSample;
  logic               burstGood;

  assign invX        = FULL_SCALE - fifoData[X_LSB +: COORD_W];
  assign invY        = FULL_SCALE - fifoData[Y_LSB +: COORD_W];
  assign isAvgSample = (sampleCount == IDX_A) || (sampleCount == IDX_B);
  assign burstGood   = (sampleCount == BURST_C) && !penLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCount <= '0;
      sumX        <= '0;
      sumY        <= '0;
      penLast     <= 1'b1;
    end else if (strobe.clear) begin
      sampleCount <= '0;
      sumX        <= '0;
      sumY        <= '0;
      penLast     <= 1'b1;
    end else if (strobe.capture) begin
      sampleCount <= sampleCount + 1'b1;
      penLast     <= fifoData[PEN_BIT];
      if (isAvgSample) begin
        sumX <= sumX + {1'b0, invX};
        sumY <= sumY + {1'b0, invY};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reportValid <= 1'b0;
      touchDown   <= 1'b0;
      coordX      <= '0;
      coordY      <= '0;
    end else begin
      reportValid <= strobe.publish;
      if (strobe.publish) begin
        touchDown <= burstGood;
        coordX    <= burstGood ? sumX[COORD_W:1] : '0;
        coordY    <= burstGood ? sumY[COORD_W:1] : '0;
      end
    end
  end
endmodule

// File: rtl/tbf_control.sv
module tbf_control
  import tbf_pkg::*;
#(
  parameter int BURST = 4,
  parameter int CNT_W = $clog2(BURST + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             fifoEmpty,
  input  logic             fifoOverrun,
  input  logic             fifoValid,
  input  logic [CNT_W-1:0] sampleCount,
  output logic             popReady,
  output ctrlStrobe_t      strobe
);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

  typedef enum logic [1:0] {ST_IDLE, ST_FLUSH, ST_COLLECT} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    popReady  = 1'b0;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.clear = 1'b1;
          stateNext    = fifoOverrun ? ST_FLUSH : ST_COLLECT;
        end
      end
      ST_FLUSH: begin
        if (fifoEmpty) stateNext = ST_IDLE;
        else           popReady  = 1'b1;
      end
      ST_COLLECT: begin
        if (sampleCount == BURST_C || fifoEmpty) begin
          strobe.publish = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          popReady       = 1'b1;
          strobe.capture = fifoValid;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/touch_burst_filter.sv
module touch_burst_filter
  import tbf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 10,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int BURST   = 4,
  parameter int AVG_A   = 1,
  parameter int AVG_B   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               fifoEmpty,
  input  logic               fifoOverrun,
  input  logic               fifoValid,
  input  logic [DATA_W-1:0]  fifoData,
  output logic               popReady,
  output logic               reportValid,
  output logic               touchDown,
  output logic [COORD_W-1:0] coordX,
  output logic [COORD_W-1:0] coordY
);
  localparam int CNT_W = $clog2(BURST + 1);

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] sampleCount;

  tbf_control #(.BURST(BURST), .CNT_W(CNT_W)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .fifoEmpty   (fifoEmpty),
    .fifoOverrun (fifoOverrun),
    .fifoValid   (fifoValid),
    .sampleCount (sampleCount),
    .popReady    (popReady),
    .strobe      (strobe)
  );

  tbf_datapath #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .X_LSB(X_LSB), .Y_LSB(Y_LSB),
    .PEN_BIT(PEN_BIT), .BURST(BURST), .AVG_A(AVG_A), .AVG_B(AVG_B), .CNT_W(CNT_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fifoData    (fifoData),
    .sampleCount (sampleCount),
    .reportValid (reportValid),
    .touchDown   (touchDown),
    .coordX      (coordX),
    .coordY      (coordY)
  );
endmodule

// File: rtl/tbf_checker.sv
module tbf_checker #(
  parameter int COORD_W = 10,
  parameter int BURST   = 4,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               fifoEmpty,
  input logic               popReady,
  input logic               reportValid,
  input logic               touchDown,
  input logic [COORD_W-1:0] coordX,
  input logic [COORD_W-1:0] coordY,
  input logic [CNT_W-1:0]   sampleCount
);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reportValid |=> !reportValid); // R8
  AST_UP_ZEROED: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && !touchDown) |-> (coordX == '0 && coordY == '0)); // R6
  AST_DOWN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && touchDown) |-> (sampleCount == BURST_C)); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sampleCount <= BURST_C); // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    popReady |-> !fifoEmpty); // R10
  AST_REPORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reportValid |-> !popReady); // R8
endmodule

bind touch_burst_filter tbf_checker #(
  .COORD_W(COORD_W), .BURST(BURST), .CNT_W(CNT_W)
) u_tbf_checker (
  .clk         (clk),
  .rstN        (rstN),
  .fifoEmpty   (fifoEmpty),
  .popReady    (popReady),
  .reportValid (reportValid),
  .touchDown   (touchDown),
  .coordX      (coordX),
  .coordY      (coordY),
  .sampleCount (sampleCount)
);

// File: tb/test_touch_burst_filter.sv
`timescale 1ns/1ps
module test_touch_burst_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        fifoOverrun = 1'b0;
  logic        holdValid = 1'b0;
  logic        fifoEmpty, fifoValid;
  logic [31:0] fifoData;
  logic        popReady, reportValid, touchDown;
  logic [9:0]  coordX, coordY;

  logic [31:0] mem [16];
  int          wrPtr = 0;
  int          rdPtr = 0;
  int          popCount = 0;
  int          reportCnt = 0;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoValid = !fifoEmpty && !holdValid;
  assign fifoData  = mem[rdPtr[3:0]];

  always @(posedge clk) begin
    if (popReady && fifoValid) begin
      rdPtr    <= rdPtr + 1;
      popCount <= popCount + 1;
    end
    if (reportValid) reportCnt <= reportCnt + 1;
  end

  touch_burst_filter i_touch_burst_filter (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .fifoEmpty(fifoEmpty),
    .fifoOverrun(fifoOverrun), .fifoValid(fifoValid), .fifoData(fifoData),
    .popReady(popReady), .reportValid(reportValid), .touchDown(touchDown),
    .coordX(coordX), .coordY(coordY)
  );

  function automatic logic [31:0] mk(input logic pen, input int x, input int y);
    return {pen, 5'b0, 10'(x), 6'b0, 10'(y)};
  endfunction

  function automatic int avgInv(input int a, input int b);
    return ((1023 - a) + (1023 - b)) / 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    mem[wrPtr % 16] = w;
    wrPtr++;
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  // Wait for a report; returns at the negedge where reportValid is high.
  task automatic waitReport(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (reportValid) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic runBurst(input string req, input bit expDown, input int ex,
                          input int ey, input int expPops);
    int  p0, r0;
    bit  seen;
    p0 = popCount;
    r0 = reportCnt;
    pulseStart();
    waitReport(seen);
    check({req, " report seen"}, int'(seen), 1);
    check({req, " touchDown"}, int'(touchDown), int'(expDown));
    check({req, " coordX"}, int'(coordX), ex);
    check({req, " coordY"}, int'(coordY), ey);
    check({req, " pops"}, popCount - p0, expPops);
    @(negedge clk);
    check({req, " strobe one cycle R8"}, int'(reportValid), 0);
    repeat (5) @(negedge clk);
    check({req, " single report R8"}, reportCnt - r0, 1);
  endtask

  task automatic testReset();
    check("R1 popReady", int'(popReady), 0);
    check("R1 reportValid", int'(reportValid), 0);
    check("R1 touchDown", int'(touchDown), 0);
    check("R1 coords", int'(coordX) + int'(coordY), 0);
  endtask

  task automatic testFullDown();
    push(mk(1'b0, 10'h200, 10'h010));
    push(mk(1'b0, 10'h100, 10'h050));
    push(mk(1'b0, 10'h0FF, 10'h052));
    push(mk(1'b0, 10'h300, 10'h3F0));
    runBurst("R3 R4 R5 full down", 1'b1, avgInv(10'h100, 10'h0FF),
             avgInv(10'h050, 10'h052), 4);
  endtask

  task automatic testExtremes();
    push(mk(1'b0, 10'h3FF, 10'h3FF));
    push(mk(1'b0, 0, 0));
    push(mk(1'b0, 0, 0));
    push(mk(1'b0, 10'h3FF, 10'h3FF));
    runBurst("R4 zero raw carry", 1'b1, 10'h3FF, 10'h3FF, 4);
    push(mk(1'b0, 0, 0));
    push(mk(1'b0, 10'h3FF, 10'h3FF));
    push(mk(1'b0, 10'h3FE, 10'h3FF));
    push(mk(1'b0, 0, 0));
    runBurst("R4 full raw truncation", 1'b1, 0, 0, 4);
  endtask

  task automatic testPenFlags();
    push(mk(1'b0, 10'h120, 10'h080));
    push(mk(1'b0, 10'h121, 10'h081));
    push(mk(1'b0, 10'h122, 10'h082));
    push(mk(1'b1, 10'h123, 10'h083));
    runBurst("R5 R6 last pen up", 1'b0, 0, 0, 4);
    push(mk(1'b1, 10'h010, 10'h020));
    push(mk(1'b1, 10'h011, 10'h021));
    push(mk(1'b1, 10'h013, 10'h024));
    push(mk(1'b0, 10'h014, 10'h025));
    runBurst("R5 early pen up ignored", 1'b1, avgInv(10'h011, 10'h013),
             avgInv(10'h021, 10'h024), 4);
  endtask

  task automatic testShort();
    push(mk(1'b0, 10'h050, 10'h060));
    push(mk(1'b0, 10'h051, 10'h061));
    push(mk(1'b0, 10'h052, 10'h062));
    runBurst("R2 R6 three samples", 1'b0, 0, 0, 3);
    runBurst("R2 R6 empty fifo", 1'b0, 0, 0, 0);
  endtask

  task automatic testExcess();
    for (int i = 0; i < 6; i++) push(mk(1'b0, 10'h040 + i, 10'h070 + 2 * i));
    runBurst("R2 six queued", 1'b1, avgInv(10'h041, 10'h042),
             avgInv(10'h072, 10'h074), 4);
    check("R2 leftover words", wrPtr - rdPtr, 2);
    runBurst("R2 R6 leftover drained", 1'b0, 0, 0, 2);
  endtask

  task automatic testOverrun();
    int p0, r0;
    for (int i = 0; i < 3; i++) push(mk(1'b0, 10'h0AA, 10'h055));
    p0 = popCount;
    r0 = reportCnt;
    @(negedge clk) fifoOverrun = 1'b1;
    pulseStart();
    fifoOverrun = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 flushed pops", popCount - p0, 3);
    check("R7 fifo empty", int'(fifoEmpty), 1);
    check("R7 no report", reportCnt - r0, 0);
    check("R7 touchDown held", int'(touchDown), 0);
    check("R7 popReady idle", int'(popReady), 0);
  endtask

  task automatic testBusyStart();
    int  p0, r0;
    bit  seen;
    push(mk(1'b0, 10'h180, 10'h090));
    push(mk(1'b0, 10'h181, 10'h091));
    push(mk(1'b0, 10'h185, 10'h096));
    push(mk(1'b0, 10'h186, 10'h097));
    p0 = popCount;
    r0 = reportCnt;
    @(negedge clk) holdValid = 1'b1;
    pulseStart();
    repeat (3) @(negedge clk);
    check("R10 no pop without valid", popCount - p0, 0);
    holdValid = 1'b0;
    for (int i = 0; i < 20 && (popCount - p0) < 2; i++) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    waitReport(seen);
    check("R9 report seen", int'(seen), 1);
    check("R9 touchDown", int'(touchDown), 1);
    check("R9 coordX", int'(coordX), avgInv(10'h181, 10'h185));
    check("R9 coordY", int'(coordY), avgInv(10'h091, 10'h096));
    repeat (10) @(negedge clk);
    check("R9 single report", reportCnt - r0, 1);
    check("R9 pops", popCount - p0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testFullDown();
    testExtremes();
    testPenFlags();
    testShort();
    testExcess();
    testOverrun();
    testBusyStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule